// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a supervision counter clocked by the system clock. It asks the chip's reset controller for a reset when software fails to restart it within the selected timeout. Every reset leaves the counter enabled, unlocked and set to its longest timeout, so protection is in place before any software has run. Software talks to the block through byte writes on a small write port, one command per write. A restart command reloads the counter and also turns a disabled counter back on. An interval command chooses one of four power-of-two timeouts. Turning the counter off takes a two-write key sequence. A lock command makes the counter impossible to turn off until the next reset.

The reset request is a one-cycle pulse meant for a reset controller. The block drives no external pin with it. The `running` and `locked` outputs show the enable and lock state. The asynchronous active-low reset input goes through an internal two-stage synchronizer before it releases the logic.

Top module: `wdog_core`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first write, `running` is 1, `locked` is 0, `rst_req` is 0 and the interval code is 3.
- R2: If no write is made after `rst_n` is released, the first `rst_req` pulse appears on rising edge number 1026 after the release. That is the 1024-cycle timeout plus two cycles of reset synchronization.
- R3: `rst_req` is high for exactly one cycle. It rises on the rising edge that ends a full timeout counted from the last reload edge. With no further reload it repeats every timeout.
- R4: A write of 0x30 + s, where s is 0 to 3, selects a timeout of 2^(4+2s) cycles (16, 64, 256 or 1024) and reloads the counter. It does not change `running`.
- R5: A write of 0xA5 reloads the counter, so the next pulse comes one timeout after the edge that sampled the write. Restarts spaced less than one timeout apart prevent any pulse. If the counter is disabled, the same write enables it.
- R6: A write of 0xDE followed by a write of 0xAD as the very next write, with idle cycles allowed between them, clears `running`. While `running` is 0, no pulse is issued and the counter is held at zero.
- R7: These patterns leave `running` at 1: 0xDE on its own, 0xAD followed by 0xDE, and 0xDE followed by any other write before 0xAD.
- R8: A write of 0xC3 sets `locked`. From then until `rst_n` is asserted, the disable sequence is ignored. Interval select and restart keep working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one command byte |
| wr_data | input | 8 | Command byte |
| rst_req | output | 1 | One-cycle reset request to the reset controller |
| running | output | 1 | Counter enabled |
| locked | output | 1 | Disable sequence is blocked |

## Verification
The timeout path is tried four ways, and each separates a different kind of fault:
- A free run straight out of reset shows whether the default timeout and the synchronizer delay are right.
- Each of the four interval codes, with repeated overflows at the shortest one, shows whether the limit decode and the wrap-around are right.
- Restarts spaced just inside the timeout show whether reloading suppresses the pulse.
- A long disabled stretch shows whether a stopped counter stays silent.

The key sequence is tried in the correct order with idle gaps, in reverse order, on its own, and broken by other writes, to tell a real two-step check from a single-key decode. Trying it again while locked and after a fresh reset shows whether the lock blocks it and whether reset clears the lock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] CMD_KICK   = 8'hA5;
  localparam logic [7:0] CMD_KEY1   = 8'hDE;
  localparam logic [7:0] CMD_KEY2   = 8'hAD;
  localparam logic [7:0] CMD_LOCK   = 8'hC3;
  localparam logic [5:0] CMD_SEL_HI = 6'b001100;

  localparam int SEL_W   = 2;
  localparam int NUM_SEL = 1 << SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic kick;
    logic key1;
    logic key2;
    logic lock;
    logic sel_wr;
    sel_t sel;
  } cmd_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/wdog_cmd.sv
module wdog_cmd
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       en,
  output logic       lock,
  output sel_t       sel,
  output logic       reload,
  output logic       halt
);
  cmd_t cmd;
  logic en_q, en_d;
  logic lock_q, lock_d;
  logic armed_q, armed_d;
  sel_t sel_q, sel_d;
  logic state_ce;

  // Decode the command byte into one-hot actions.
  always_comb begin
    cmd        = '0;
    cmd.kick   = (wr_data == CMD_KICK);
    cmd.key1   = (wr_data == CMD_KEY1);
    cmd.key2   = (wr_data == CMD_KEY2);
    cmd.lock   = (wr_data == CMD_LOCK);
    cmd.sel_wr = (wr_data[7:SEL_W] == CMD_SEL_HI);
    cmd.sel    = wr_data[SEL_W-1:0];
  end

  // The second key counts only if the previous write was the first key.
  assign halt   = wr_en && cmd.key2 && armed_q && !lock_q;
  assign reload = wr_en && (cmd.kick || cmd.sel_wr);

  always_comb begin
    armed_d = armed_q;
    en_d    = en_q;
    lock_d  = lock_q;
    sel_d   = sel_q;
    if (wr_en) begin
      armed_d = cmd.key1;
      if (halt)       en_d   = 1'b0;
      if (cmd.kick)   en_d   = 1'b1;
      if (cmd.lock)   lock_d = 1'b1;
      if (cmd.sel_wr) sel_d  = cmd.sel;
    end
  end

  assign state_ce = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      en_q    <= 1'b1;
      lock_q  <= 1'b0;
      sel_q   <= '1;
    end else if (state_ce) begin
      armed_q <= armed_d;
      en_q    <= en_d;
      lock_q  <= lock_d;
      sel_q   <= sel_d;
    end
  end

  assign en   = en_q;
  assign lock = lock_q;
  assign sel  = sel_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int STEP_LOG2 = 2,
  parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic halt,
  input  logic reload,
  input  sel_t sel,
  output logic rst_req
);
  logic [CNT_W-1:0] last_val [NUM_SEL];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             cnt_ce;
  logic             at_end;

  // Terminal count for each interval code.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    localparam int LIM = 1 << (BASE_LOG2 + STEP_LOG2 * g);
    assign last_val[g] = CNT_W'(LIM - 1);
  end

  assign at_end = (cnt_q >= last_val[sel]);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    req_d = 1'b0;
    if (!en || halt || reload) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
      req_d = 1'b1;
    end
  end

  assign cnt_ce = en || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       rst_req,
  output logic       running,
  output logic       locked
);
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1);

  logic rst_int_n;
  logic en;
  logic halt;
  logic reload;
  sel_t sel;

  wdog_rst_sync u_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  wdog_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .en      (en),
    .lock    (locked),
    .sel     (sel),
    .reload  (reload),
    .halt    (halt)
  );

  wdog_count #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (en),
    .halt    (halt),
    .reload  (reload),
    .sel     (sel),
    .rst_req (rst_req)
  );

  assign running = en;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rst_req,
  input logic       running,
  input logic       locked
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R3

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rst_req); // R6

  AST_KICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hA5) |=> !rst_req); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R8

  AST_LOCKED_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && running) |=> running); // R8

  AST_LONE_KEY_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && wr_data == 8'hDE) |=> running); // R7
endmodule

bind wdog_core wdog_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rst_req (rst_req),
  .running (running),
  .locked  (locked)
);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rst_req;
  logic       running;
  logic       locked;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int    at;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  wdog_core u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rst_req (rst_req),
    .running (running),
    .locked  (locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every pulse must match the oldest expected pulse cycle.
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3: unexpected rst_req at cycle %0d (actual 1, expected 0)", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.at != cyc) begin
          n_bad++;
          $display("FAIL %s: rst_req pulse at cycle %0d, expected %0d", e.tag, cyc, e.at);
        end
      end
    end
  end

  task automatic expect_pulse(input int at, input string tag);
    exp_t e;
    e.at  = at;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one write; the write is sampled on edge at+1.
  task automatic wr(input logic [7:0] v, output int at);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    at      = cyc;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 150000)", cyc);
      summary();
    end
  end

  initial begin
    int t;
    int c0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    idle(4);
    // R1: reset state
    chk("R1 running", running, 1);
    chk("R1 locked", locked, 0);
    chk("R1 rst_req", rst_req, 0);

    // R2: free run from reset with the default longest interval
    @(negedge clk);
    c0 = cyc;
    rst_n = 1'b1;
    expect_pulse(c0 + 1026, "R2");
    wait_until(c0 + 1027);

    // R4 + R3: shortest interval, periodic overflow
    wr(8'h30, t);
    expect_pulse(t + 1 + 16, "R4");
    expect_pulse(t + 1 + 32, "R3");
    expect_pulse(t + 1 + 48, "R3");
    wait_until(t + 1 + 49);
    chk("R4 running", running, 1);

    // R5: restarts every ~40 cycles at the 64-cycle interval
    wr(8'h31, t);
    for (int i = 0; i < 5; i++) begin
      idle(38);
      wr(8'hA5, t);
    end
    expect_pulse(t + 1 + 64, "R5");
    wait_until(t + 1 + 65);

    // R4: 256 and 1024 cycle intervals
    wr(8'h32, t);
    expect_pulse(t + 1 + 256, "R4");
    wait_until(t + 1 + 257);
    wr(8'h33, t);
    expect_pulse(t + 1 + 1024, "R4");
    wait_until(t + 1 + 1025);

    // R6: key pair with idle gap disables; stays silent
    wr(8'hDE, t);
    idle(3);
    wr(8'hAD, t);
    chk("R6 running after keys", running, 0);
    idle(3000);
    chk("R6 running stays off", running, 0);

    // R4: interval write does not enable
    wr(8'h31, t);
    chk("R4 interval keeps off", running, 0);

    // R5: restart re-enables
    wr(8'hA5, t);
    chk("R5 restart enables", running, 1);

    // R7: wrong orders and broken sequences
    wr(8'hAD, t);
    wr(8'hDE, t);
    chk("R7 reversed keys", running, 1);
    wr(8'hA5, t);
    wr(8'hAD, t);
    chk("R7 keys split by restart", running, 1);
    wr(8'hDE, t);
    idle(5);
    chk("R7 lone first key", running, 1);
    wr(8'h55, t);
    wr(8'hAD, t);
    chk("R7 keys split by other write", running, 1);
    expect_pulse(0, "R7");
    exp_q.pop_back();
    wait_until(cyc + 1);
    // last reload was the 0xA5 write before the split
    begin
      int dummy;
      dummy = 0;
    end
    // pulse is expected 64 cycles after that restart; recompute below
    idle(1);
    // Re-sync cleanly: restart and wait for the pulse
    wr(8'hA5, t);
    expect_pulse(t + 1 + 64, "R5");
    wait_until(t + 1 + 65);

    // R8: lock blocks disabling, restart and interval still work
    wr(8'hA5, t);
    c0 = t;
    wr(8'hC3, t);
    chk("R8 locked set", locked, 1);
    wr(8'hDE, t);
    wr(8'hAD, t);
    chk("R8 disable ignored", running, 1);
    expect_pulse(c0 + 1 + 64, "R8");
    wait_until(c0 + 1 + 65);
    wr(8'h30, t);
    expect_pulse(t + 1 + 16, "R8");
    wait_until(t + 1 + 17);
    wr(8'hA5, t);
    chk("R8 still locked", locked, 1);

    // R1/R8: reset clears lock; disable works again
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    chk("R1 lock cleared", locked, 0);
    chk("R1 running after reset", running, 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    wr(8'hDE, t);
    wr(8'hAD, t);
    chk("R8 disable after reset", running, 0);
    idle(1200);

    chk("R3 all pulses seen", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule